// File: doc/BRIEF.md
# Multicycle Multiply/Divide Unit

This unit performs the two long arithmetic operations of an 8-bit CPU core. An unsigned multiply forms the 16-bit product of the index byte X and the accumulator A. The high byte goes back to X and the low byte to A. An unsigned divide takes the 16-bit value H:A as the dividend and X as the divisor. It returns the quotient in A and the remainder in H. Each operation takes a fixed number of cycles that does not depend on the operand values, so the sequencer of the core can schedule around it without a handshake.

The core presents the current H, A, X and the carry, zero and half-carry flags, selects the operation and pulses `start`. On the start edge the unit copies all of these values into its output registers. When the operation finishes, it overwrites the registers and flags that the operation produces. Values the operation does not touch therefore come back unchanged. `done` pulses for one cycle when the outputs are valid. The outputs then hold until the next accepted start. Both the multiply and the divide handle two operand bits per cycle.

Top module: `muldiv_unit`

## Requirements
- R1: After reset all result and flag outputs are 0, and `busy` and `done` are 0.
- R2: Multiply (`op_div`=0) gives {res_x,res_a} = in_x × in_a (unsigned), with res_x the high byte, and gives res_h = in_h.
- R3: Multiply sets flag_c=0 and flag_hc=0 and returns flag_z equal to in_z.
- R4: A multiply accepted at clock edge k raises `done` after edge k+5, for exactly one cycle.
- R5: Divide with in_h < in_x gives res_a = (in_h:in_a) / in_x and res_h = the remainder. It also gives res_x = in_x, flag_c=0, flag_z=1 exactly when the quotient is 0, and flag_hc = in_hc.
- R6: Divide with in_h ≥ in_x (this covers in_x = 0 and every quotient wider than 8 bits) gives res_a=8'hFF, res_h=8'hFF, res_x = in_x, flag_c=1, flag_z=0 and flag_hc = in_hc.
- R7: A divide accepted at edge k raises `done` after edge k+7 for one cycle, whether or not the divide overflows.
- R8: A `start` while `busy`=1 has no effect: the running operation finishes at its own time with its own result, and no extra `done` follows.
- R9: `busy` is 1 from the accept edge until `done` rises. While the unit is idle and `start` is low, all result and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| in_h | input | 8 | Index high byte / dividend high byte |
| in_a | input | 8 | Accumulator / multiplier / dividend low byte |
| in_x | input | 8 | Index low byte / multiplicand / divisor |
| in_c | input | 1 | Incoming carry flag |
| in_z | input | 1 | Incoming zero flag |
| in_hc | input | 1 | Incoming half-carry flag |
| res_h | output | 8 | H result register |
| res_a | output | 8 | A result register |
| res_x | output | 8 | X result register |
| flag_c | output | 1 | Carry flag result |
| flag_z | output | 1 | Zero flag result |
| flag_hc | output | 1 | Half-carry flag result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, outputs valid |

## Verification
The bench targets the overflow boundary of the divide. H equal to X must saturate, while H one below X with a large low byte (FE:FF / FF) must give quotient FF and remainder FE. A comparison off by one would either return a truncated quotient or flag a valid case as an error. X = 0 must take the saturated path in the full 7 cycles and must not yield a garbage quotient. A zero product and a zero quotient check that the zero flag is taken from the right place: it must pass through on a multiply and follow the result on a divide. A start issued during a multiply must not corrupt the result or add a second `done`. The latency checks catch any step counter that is off by one.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} op_e;
  localparam int unsigned MUL_CYCLES = 5;
  localparam int unsigned DIV_CYCLES = 7;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int unsigned MUL_LAT = MUL_CYCLES,
  parameter int unsigned DIV_LAT = DIV_CYCLES,
  parameter int unsigned STEPS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  op_in,
  output logic busy,
  output logic load,
  output logic step,
  output logic finish,
  output op_e  op_q
);
  localparam int unsigned MAXLAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int unsigned CW = $clog2(MAXLAT);
  localparam logic [CW-1:0] STEPS_C  = CW'(STEPS);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_LAT - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign load   = start & ~busy;
  assign step   = busy & (cnt < STEPS_C);
  assign last   = (op_q == OP_DIV) ? DIV_LAST : MUL_LAST;
  assign finish = busy & (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op_q <= OP_MUL;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      op_q <= op_in;
    end else if (busy) begin
      if (finish) busy <= 1'b0;
      else        cnt  <= cnt + 1'b1;
    end
  end

  // R8: a start during an operation does not change the running operation
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));
  // R7: the step counter never runs past the longest latency
  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= DIV_LAST || cnt <= MUL_LAST));
endmodule

// File: rtl/muldiv_mul_dp.sv
module muldiv_mul_dp #(
  parameter int unsigned W   = 8,
  parameter int unsigned BPS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] product
);
  logic [2*W-1:0] acc, mcand;
  logic [W-1:0]   mplier;

  // adds mcand shifted by each set bit of the BPS-bit multiplier slice
  function automatic logic [2*W-1:0] mul_add(input logic [2*W-1:0] s0,
                                             input logic [2*W-1:0] m,
                                             input logic [BPS-1:0] bits);
    logic [2*W-1:0] s;
    s = s0;
    for (int i = 0; i < int'(BPS); i++)
      if (bits[i]) s = s + (m << i);
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= {{W{1'b0}}, mcand_in};
      mplier <= mplier_in;
    end else if (step) begin
      acc    <= mul_add(acc, mcand, mplier[BPS-1:0]);
      mcand  <= mcand << BPS;
      mplier <= mplier >> BPS;
    end
  end

  assign product = acc;

  // R2: the partial product never drops while the multiply runs
  p_acc_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> acc >= $past(acc));
endmodule

// File: rtl/muldiv_div_dp.sv
module muldiv_div_dp #(
  parameter int unsigned W   = 8,
  parameter int unsigned BPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem_out,
  output logic         ovf
);
  logic [W-1:0] rem, shq, dvs;
  logic [W-1:0] rem_nx, shq_nx;

  // one restoring step: returns {quotient bit, new remainder}
  function automatic logic [W:0] div_bit(input logic [W-1:0] r,
                                         input logic b,
                                         input logic [W-1:0] d);
    logic [W:0] t;
    t = {r, b};
    if (t >= {1'b0, d}) begin
      t = t - {1'b0, d};
      return {1'b1, t[W-1:0]};
    end
    return {1'b0, t[W-1:0]};
  endfunction

  always_comb begin
    logic [W:0] t;
    rem_nx = rem;
    shq_nx = shq;
    for (int i = 0; i < int'(BPS); i++) begin
      t      = div_bit(rem_nx, shq_nx[W-1], dvs);
      rem_nx = t[W-1:0];
      shq_nx = {shq_nx[W-2:0], t[W]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0;
      shq <= '0;
      dvs <= '0;
      ovf <= 1'b1;
    end else if (load) begin
      rem <= hi_in;
      shq <= lo_in;
      dvs <= dvs_in;
      ovf <= !(hi_in < dvs_in);
    end else if (step) begin
      rem <= rem_nx;
      shq <= shq_nx;
    end
  end

  assign quot    = shq;
  assign rem_out = rem;

  // R5: on a valid divide the partial remainder stays below the divisor
  p_rem_below_dvs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> rem < dvs);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned BPS     = 2,
  parameter int unsigned MUL_LAT = MUL_CYCLES,
  parameter int unsigned DIV_LAT = DIV_CYCLES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] in_h,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_x,
  input  logic         in_c,
  input  logic         in_z,
  input  logic         in_hc,
  output logic [W-1:0] res_h,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_x,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_hc,
  output logic         busy,
  output logic         done
);
  localparam int unsigned STEPS = W / BPS;

  logic           load, step, finish;
  op_e            op_q;
  logic [2*W-1:0] product;
  logic [W-1:0]   quot, rem;
  logic           div_ovf;

  muldiv_seq #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_e'(op_div)),
    .busy(busy), .load(load), .step(step), .finish(finish), .op_q(op_q));

  muldiv_mul_dp #(.W(W), .BPS(BPS)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mcand_in(in_x), .mplier_in(in_a), .product(product));

  muldiv_div_dp #(.W(W), .BPS(BPS)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .hi_in(in_h), .lo_in(in_a), .dvs_in(in_x),
    .quot(quot), .rem_out(rem), .ovf(div_ovf));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_h <= '0; res_a <= '0; res_x <= '0;
      flag_c <= 1'b0; flag_z <= 1'b0; flag_hc <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (load) begin
        res_h <= in_h; res_a <= in_a; res_x <= in_x;
        flag_c <= in_c; flag_z <= in_z; flag_hc <= in_hc;
      end else if (finish) begin
        if (op_q == OP_MUL) begin
          res_x   <= product[2*W-1:W];
          res_a   <= product[W-1:0];
          flag_c  <= 1'b0;
          flag_hc <= 1'b0;
        end else if (div_ovf) begin
          res_a  <= '1;
          res_h  <= '1;
          flag_c <= 1'b1;
          flag_z <= 1'b0;
        end else begin
          res_a  <= quot;
          res_h  <= rem;
          flag_c <= 1'b0;
          flag_z <= (quot == '0);
        end
      end
    end
  end

  // R3: a finished multiply reports clear carry and half-carry
  p_mul_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MUL) |-> (!flag_c && !flag_hc));
  // R6: an overflowing divide reports saturated results
  p_div_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DIV && flag_c) |-> (res_a == '1 && res_h == '1 && !flag_z));
  // R5: a valid divide returns a remainder below the divisor
  p_div_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DIV && !flag_c) |-> (res_h < res_x));
  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: idle without start keeps every output
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({res_h, res_a, res_x, flag_c, flag_z, flag_hc}));
  // R9: done only appears once busy has dropped
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_div = 1'b0;
  logic [7:0] in_h = '0, in_a = '0, in_x = '0;
  logic in_c = 1'b0, in_z = 1'b0, in_hc = 1'b0;
  logic [7:0] res_h, res_a, res_x;
  logic flag_c, flag_z, flag_hc, busy, done;
  int checks = 0, fails = 0;
  logic [7:0] e_h, e_a, e_x;
  logic e_c, e_z, e_hc;

  always #5 clk = ~clk;

  muldiv_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .in_h(in_h), .in_a(in_a), .in_x(in_x), .in_c(in_c), .in_z(in_z), .in_hc(in_hc),
    .res_h(res_h), .res_a(res_a), .res_x(res_x), .flag_c(flag_c), .flag_z(flag_z),
    .flag_hc(flag_hc), .busy(busy), .done(done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model computed from the requirements
  task automatic model(input logic dv, input logic [7:0] h, a, x,
                       input logic c, z, hc);
    logic [15:0] p, q, r;
    e_h = h; e_a = a; e_x = x; e_c = c; e_z = z; e_hc = hc;
    if (!dv) begin
      p = 16'(x) * 16'(a);
      e_x = p[15:8]; e_a = p[7:0]; e_c = 1'b0; e_hc = 1'b0;
    end else if (x == 8'd0 || h >= x) begin
      e_a = 8'hFF; e_h = 8'hFF; e_c = 1'b1; e_z = 1'b0;
    end else begin
      q = {h, a} / {8'd0, x};
      r = {h, a} % {8'd0, x};
      e_a = q[7:0]; e_h = r[7:0]; e_c = 1'b0; e_z = (q == 16'd0);
    end
  endtask

  task automatic run_op(input logic dv, input logic [7:0] h, a, x,
                        input logic c, z, hc, input logic poke);
    int lat;
    logic bad_done;
    lat = dv ? 7 : 5;
    bad_done = 1'b0;
    model(dv, h, a, x, c, z, hc);
    @(negedge clk);
    op_div = dv; in_h = h; in_a = a; in_x = x; in_c = c; in_z = z; in_hc = hc;
    start = 1'b1;
    for (int j = 1; j <= lat + 1; j++) begin
      @(negedge clk);
      if (done !== (j == lat + 1)) bad_done = 1'b1;
      if (j <= lat && busy !== 1'b1) bad_done = 1'b1;
      if (j == 1) start = 1'b0;
      if (j == 2 && poke) begin
        op_div = ~dv; in_h = 8'h01; in_a = 8'h23; in_x = 8'h45; in_c = ~c;
        start = 1'b1;
      end
      if (j == 3 && poke) start = 1'b0;
    end
    chk(dv ? "R7 latency" : "R4 latency", bad_done, 1'b0);
    chk(dv ? "R5/R6 res_a" : "R2 res_a", res_a, e_a);
    chk(dv ? "R5/R6 res_h" : "R2 res_h", res_h, e_h);
    chk(dv ? "R5/R6 res_x" : "R2 res_x", res_x, e_x);
    chk(dv ? "R5/R6 flags" : "R3 flags", {flag_c, flag_z, flag_hc}, {e_c, e_z, e_hc});
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk("R8 no extra done", {done, busy}, 2'b00);
        chk("R9 hold", {res_h, res_a, res_x, flag_c, flag_z, flag_hc},
            {e_h, e_a, e_x, e_c, e_z, e_hc});
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {res_h, res_a, res_x, flag_c, flag_z, flag_hc, busy, done}, 32'd0);
    // directed corners
    run_op(1'b0, 8'h11, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
    run_op(1'b0, 8'h22, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op(1'b0, 8'h00, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 8'h00, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(1'b1, 8'h40, 8'h00, 8'h40, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(1'b1, 8'hFE, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
    run_op(1'b1, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(1'b1, 8'h00, 8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 8'h00, 8'h05, 8'h07, 1'b0, 1'b0, 1'b1, 1'b0);
    // start while busy
    run_op(1'b0, 8'h5A, 8'hC3, 8'h9E, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op(1'b1, 8'h12, 8'h34, 8'h56, 1'b1, 1'b1, 1'b1, 1'b1);
    // constrained random: divides kept mostly in range
    for (int n = 0; n < 400; n++) begin
      logic dv;
      logic [7:0] h, a, x;
      logic [2:0] fl;
      dv = 1'($urandom);
      a  = 8'($urandom);
      x  = 8'($urandom);
      fl = 3'($urandom);
      h  = 8'($urandom);
      if (dv && x != 8'd0 && ($urandom % 4) != 0) h = 8'($urandom % x);
      run_op(dv, h, a, x, fl[2], fl[1], fl[0], (n % 50) == 7);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule